// File: doc/BRIEF.md
# Shared-Bus Register-File Memory

A small synchronous word store built entirely from reset flip-flops. A processor-style master reaches it through an address input, a write-enable input and one bidirectional data bus. While no write is pending, the memory owns the bus and drives the word at the latched address onto it. A write uses the bus in two phases. In the first cycle the master raises write-enable and presents the address, and the memory lets go of the bus at the next clock edge. In the second cycle the master drives the data, and the word is captured at the end of that cycle. This one-cycle turnaround means the two sides never drive the bus at the same time.

The memory also reports that it is driving the bus through `rd_oe_o`. A pad or bus keeper can use this signal to steer direction. A parameter replaces the shared bus with separate write-data and read-data ports, so that no internal signal needs to go high-impedance. The default geometry is 64 words of 8 bits, addressed by 6 bits.

Top module: `rfb_bidir_ram`

## Requirements
- R1: After reset every word reads as zero, and the memory drives the bus (`rd_oe_o` = 1).
- R2: With write-enable low, the word stored at the address presented in one cycle appears on `bus_io` and `rd_data_o` in the following cycle.
- R3: In the cycle after write-enable is first sampled high, `rd_oe_o` is 0 and the memory no longer drives `bus_io`.
- R4: A word is stored at a rising edge only when write-enable is high in that cycle and the bus was already released during that cycle. The value on `bus_io` is written to the address latched in the first write cycle.
- R5: A write request that is withdrawn after its first cycle, before any data phase, leaves every stored word unchanged.
- R6: While the bus is released, changes on `addr_i` are ignored, and the write goes to the address latched when the bus was released.
- R7: The memory drives the bus again in the cycle after write-enable is sampled low.
- R8: In shared-bus mode (`SHARED_BUS` = 1), `wr_data_i` has no effect on stored data.
- R9: A master that drives the bus only while `rd_oe_o` is 0 never contends with the memory. Over any write sequence, `rd_oe_o` and the master's drive are never both active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | AW (6) | Word address, latched while the memory owns the bus |
| we_i | input | 1 | Write request; held high through the address and data phases |
| bus_io | inout | DW (8) | Shared data bus: read data out, write data in |
| wr_data_i | input | DW (8) | Write data in split-port mode; ignored when the bus is shared |
| rd_data_o | output | DW (8) | Word at the latched address, always presented |
| rd_oe_o | output | 1 | High while the memory drives `bus_io` |

## Verification
Every one of the 64 addresses is written and read back with two arithmetic data patterns. One is address-derived and the other is its bitwise inverse, so each bit cell is seen at both values and an address-decode alias shows up as a wrong word. During those writes, `wr_data_i` carries the complement of the bus data, so if the write path took the wrong source, every word would come back inverted. The aborted-write and address-change cases tell a correct two-phase capture apart from one that writes in the first cycle or follows a late address. A per-cycle monitor compares the master's drive against `rd_oe_o` to confirm the turnaround.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int unsigned RFB_AW = 6;
  localparam int unsigned RFB_DW = 8;
endpackage

// File: rtl/rfb_rst_sync.sv
module rfb_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/rfb_ctrl.sv
module rfb_ctrl #(
  parameter int unsigned AW = rfb_pkg::RFB_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          oe_o,
  output logic          wr_en_o
);
  logic          we_q, we_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_ld;

  always_comb begin
    we_d    = we_i;
    addr_ld = ~we_q;
    addr_d  = addr_ld ? addr_i : addr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      we_q   <= we_d;
      addr_q <= addr_d;
    end
  end

  assign oe_o    = ~we_q;
  assign wr_en_o = we_i & we_q;
  assign addr_o  = addr_q;

  // R3
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !oe_o);

  // R7
  reclaim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> oe_o);

  // R6
  addr_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |=> $stable(addr_o));
endmodule

// File: rtl/rfb_array.sv
module rfb_array #(
  parameter int unsigned AW = rfb_pkg::RFB_AW,
  parameter int unsigned DW = rfb_pkg::RFB_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] words;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic          hit;
    logic [DW-1:0] word_q, word_d;

    assign hit = wr_en_i && (addr_i == AW'(w));

    always_comb begin
      word_d = hit ? wr_data_i : word_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else         word_q <= word_d;
    end

    assign words[w] = word_q;
  end

  assign rd_data_o = words[addr_i];

  // R5
  stable_unless_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(words));
endmodule

// File: rtl/rfb_bidir_ram.sv
module rfb_bidir_ram #(
  parameter int unsigned AW         = rfb_pkg::RFB_AW,
  parameter int unsigned DW         = rfb_pkg::RFB_DW,
  parameter bit          SHARED_BUS = 1'b1
) (
  input  logic          clk_i,
  input  logic          arst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  inout  wire  [DW-1:0] bus_io,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_oe_o
);
  logic          rst_n;
  logic [AW-1:0] addr_q;
  logic          oe;
  logic          wr_en;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;

  rfb_rst_sync u_rst (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .rst_no (rst_n)
  );

  rfb_ctrl #(.AW(AW)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .we_i   (we_i),
    .addr_i (addr_i),
    .addr_o (addr_q),
    .oe_o   (oe),
    .wr_en_o(wr_en)
  );

  assign wdata = SHARED_BUS ? bus_io : wr_data_i;

  rfb_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .addr_i   (addr_q),
    .wr_data_i(wdata),
    .rd_data_o(rdata)
  );

  if (SHARED_BUS) begin : g_shared
    assign bus_io = oe ? rdata : {DW{1'bz}};
  end else begin : g_split
    assign bus_io = {DW{1'bz}};
  end

  assign rd_data_o = rdata;
  assign rd_oe_o   = SHARED_BUS ? oe : 1'b0;
endmodule

// File: tb/rfb_bidir_ram_tb.sv
module rfb_bidir_ram_tb_top;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic          m_oe = 1'b0;
  logic [DW-1:0] m_data = '0;
  logic [DW-1:0] wr_alt = '0;
  logic [DW-1:0] rd_data;
  logic          rd_oe;
  wire  [DW-1:0] bus;

  logic [DW-1:0] ref_mem [DEPTH];
  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  assign bus = m_oe ? m_data : {DW{1'bz}};

  always #5 clk = ~clk;

  rfb_bidir_ram dut_i (
    .clk_i    (clk),
    .arst_ni  (arst_n),
    .addr_i   (addr),
    .we_i     (we),
    .bus_io   (bus),
    .wr_data_i(wr_alt),
    .rd_data_o(rd_data),
    .rd_oe_o  (rd_oe)
  );

  // R9 contention monitor: sampled at the edge, inputs settled since negedge
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (arst_n && m_oe) begin
      vectors++;
      if (rd_oe) begin
        errors++;
        $display("FAIL R9 contention: rd_oe=%0d master_drive=%0d expected rd_oe=0", rd_oe, m_oe);
      end
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'(a * 37 + k * 11 + (a >> 1)) ^ DW'(k);
  endfunction

  task automatic do_read(input int a, input string req);
    @(negedge clk);
    addr = AW'(a); we = 1'b0; m_oe = 1'b0;
    @(negedge clk);
    chk({req, " bus"}, bus, ref_mem[a]);
    chk({req, " rd_data"}, rd_data, ref_mem[a]);
    chk({req, " rd_oe"}, DW'(rd_oe), DW'(1));
  endtask

  // two-phase write; addr_late is driven during the data phase (R6)
  task automatic do_write(input int a, input int addr_late, input logic [DW-1:0] d);
    @(negedge clk);
    addr = AW'(a); we = 1'b1; m_oe = 1'b0;
    @(negedge clk);
    chk("R3 released", DW'(rd_oe), DW'(0));
    addr = AW'(addr_late); m_oe = 1'b1; m_data = d; wr_alt = ~d;
    @(negedge clk);
    m_oe = 1'b0; we = 1'b0;
    @(negedge clk);
    chk("R7 reclaimed", DW'(rd_oe), DW'(1));
    ref_mem[a] = d;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 rd_oe after reset", DW'(rd_oe), DW'(1));
    for (int a = 0; a < DEPTH; a++) do_read(a, "R1 zero after reset");

    // R4 R8 sweep with two patterns, R2 readback
    for (int k = 0; k < 2; k++) begin
      for (int a = 0; a < DEPTH; a++)
        do_write(a, a, (k == 0) ? pat(a, 3) : ~pat(a, 3));
      for (int a = DEPTH - 1; a >= 0; a--) do_read(a, "R2 R4 R8 readback");
    end

    // R5 aborted write: first phase only
    @(negedge clk);
    addr = AW'(9); we = 1'b1; m_oe = 1'b0;
    @(negedge clk);
    we = 1'b0; addr = AW'(9);
    @(negedge clk);
    do_read(9, "R5 aborted write");

    // R6 address change during data phase
    do_write(20, 21, 8'hA5);
    do_read(20, "R6 latched address");
    do_read(21, "R6 late address untouched");

    // R2 read at extremes after another write
    do_write(DEPTH - 1, DEPTH - 1, 8'hFF);
    do_write(0, 0, 8'h01);
    do_read(DEPTH - 1, "R2 top address");
    do_read(0, "R2 bottom address");

    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 100000) @(negedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule